// File: doc/BRIEF.md
# Stuck-Bus Watchdog and Recovery Sequencer

This block watches the output side of a two-wire clock/data bus and decides when the bus is stuck. The bus counts as stuck when clock and data never sit high together for a whole timeout window while at least one output channel is switched in. On that decision the block raises a fault flag. A strap input picks one of two reactions. In flag-only mode nothing else happens, and the flag drops once both lines are seen high again.

In disconnect mode the block also asks the surrounding switch fabric to separate the input side from the output side. It waits a guard interval and then pulls the output clock low in a train of recovery pulses, at most a fixed number of them. The train ends early when data is seen high while clock is released. A stop condition always follows the pulses. The fault flag and the isolation request drop together once both lines read high after the stop. The block then gives a one-cycle cleared pulse and monitoring starts again.

All durations are counted in system clock cycles. They are derived from the clock frequency parameter, so the timeout, guard time and pulse rate are set in physical units. The clock and data inputs must already be synchronized to the system clock.

Top module: `bus_unstick_ctrl`

## Requirements
- R1: Out of reset, and until a fault is detected, fault_o, isolate_o, scl_pull_o, sda_pull_o and cleared_o are all 0.
- R2: While chan_en_i is 1, fault_o goes to 1 on the cycle after the T-th consecutive sample in which scl_i and sda_i are not both 1. T is the timeout in cycles. A sample with both lines at 1 restarts the count.
- R3: While chan_en_i is 0, the stuck count is held at zero and no fault is raised, however long the lines stay low.
- R4: If disc_mode_i is 0 when the fault is raised, isolate_o, scl_pull_o and sda_pull_o stay 0. fault_o drops and cleared_o pulses for one cycle on the cycle after the first sample with both lines at 1.
- R5: If disc_mode_i is 1 when the fault is raised, isolate_o rises together with fault_o. scl_pull_o stays 0 for exactly G cycles after that (the guard time). No pull output is ever 1 unless isolate_o is 1.
- R6: Each recovery pulse holds scl_pull_o at 1 for H cycles and then at 0 for H cycles. H is half the pulse period. At most N pulses are issued (N = 16 by default).
- R7: If both lines are sampled at 1 in the last cycle of a released half-period, no further pulse is issued and the stop condition begins on the next cycle.
- R8: The stop condition drives sda_pull_o and scl_pull_o both to 1 for H cycles. It then keeps sda_pull_o at 1 with scl_pull_o at 0 for H cycles, and then releases sda_pull_o.
- R9: After the stop, fault_o and isolate_o stay at 1 until both lines are sampled at 1. On the next cycle both drop and cleared_o is 1 for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronized output-side clock level |
| sda_i | input | 1 | Synchronized output-side data level |
| chan_en_i | input | 1 | At least one output channel is switched in |
| disc_mode_i | input | 1 | Strap: 1 = isolate and recover, 0 = flag only |
| fault_o | output | 1 | Stuck-bus fault flag |
| isolate_o | output | 1 | Request to separate the input and output sides |
| scl_pull_o | output | 1 | Open-drain pull-down control for output clock |
| sda_pull_o | output | 1 | Open-drain pull-down control for output data |
| cleared_o | output | 1 | One-cycle pulse when a fault has been cleared |

## Verification
The hardest case to reach is an early stop in the middle of a pulse train. Data has to come free at one exact point, after a chosen number of pulses have started, so that the released half-period sees both lines high. The bench models the open-drain wires itself, combining its own hold-low controls with the block's pull outputs. It counts clock pulses as they appear and lets go of data during the third pulse. It also keeps data stuck through a full train and the stop, so that the hold-until-high path and the pulse limit are both exercised.

// File: rtl/bus_unstick_pkg.sv
package bus_unstick_pkg;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_GUARD,
    RS_LOW,
    RS_HIGH,
    RS_STP_LO,
    RS_STP_HI,
    RS_WAIT
  } rec_state_e;

  function automatic int unsigned us_to_cyc(input int unsigned clk_hz, input int unsigned us);
    int unsigned c;
    c = (clk_hz / 1_000_000) * us;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned half_period_cyc(input int unsigned clk_hz, input int unsigned pulse_hz);
    int unsigned c;
    c = clk_hz / (2 * pulse_hz);
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/stuck_timer.sv
module stuck_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic stuck_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = enable_i && stuck_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!enable_i || !stuck_i)  cnt_q <= '0;
    else if (expire_o)               cnt_q <= '0;
    else                             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/recovery_seq.sv
module recovery_seq
  import bus_unstick_pkg::*;
#(
  parameter int unsigned GUARD_CYC = 8,
  parameter int unsigned HALF_CYC  = 4,
  parameter int unsigned N_PULSES  = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic busy_o,
  output logic scl_pull_o,
  output logic sda_pull_o,
  output logic done_o
);
  localparam int unsigned MAXC = (GUARD_CYC > HALF_CYC) ? GUARD_CYC : HALF_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam int unsigned PW   = $clog2(N_PULSES + 1);
  localparam logic [CW-1:0] G_LAST = CW'(GUARD_CYC - 1);
  localparam logic [CW-1:0] H_LAST = CW'(HALF_CYC - 1);
  localparam logic [PW-1:0] P_LAST = PW'(N_PULSES - 1);

  rec_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] pls_q, pls_d;
  logic both_hi;

  assign both_hi = scl_i && sda_i;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q + 1'b1;
    pls_d = pls_q;
    unique case (st_q)
      RS_IDLE: begin
        cnt_d = '0;
        if (start_i) begin
          st_d  = RS_GUARD;
          pls_d = '0;
        end
      end
      RS_GUARD: if (cnt_q == G_LAST) begin st_d = RS_LOW; cnt_d = '0; end
      RS_LOW:   if (cnt_q == H_LAST) begin st_d = RS_HIGH; cnt_d = '0; end
      RS_HIGH: begin
        if (cnt_q == H_LAST) begin
          cnt_d = '0;
          // bus free or train exhausted: go to stop
          if (both_hi || pls_q == P_LAST) st_d = RS_STP_LO;
          else begin
            st_d  = RS_LOW;
            pls_d = pls_q + 1'b1;
          end
        end
      end
      RS_STP_LO: if (cnt_q == H_LAST) begin st_d = RS_STP_HI; cnt_d = '0; end
      RS_STP_HI: if (cnt_q == H_LAST) begin st_d = RS_WAIT; cnt_d = '0; end
      RS_WAIT: begin
        cnt_d = '0;
        if (both_hi) st_d = RS_IDLE;
      end
      default: begin st_d = RS_IDLE; cnt_d = '0; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= RS_IDLE;
      cnt_q <= '0;
      pls_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      pls_q <= pls_d;
    end
  end

  assign busy_o     = (st_q != RS_IDLE);
  assign scl_pull_o = (st_q == RS_LOW) || (st_q == RS_STP_LO);
  assign sda_pull_o = (st_q == RS_STP_LO) || (st_q == RS_STP_HI);
  assign done_o     = (st_q == RS_WAIT) && both_hi;
endmodule

// File: rtl/bus_unstick_ctrl.sv
module bus_unstick_ctrl
  import bus_unstick_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 125_000_000,
  parameter int unsigned TIMEOUT_US = 45_000,
  parameter int unsigned GUARD_US   = 40,
  parameter int unsigned PULSE_HZ   = 5_500,
  parameter int unsigned N_PULSES   = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic chan_en_i,
  input  logic disc_mode_i,
  output logic fault_o,
  output logic isolate_o,
  output logic scl_pull_o,
  output logic sda_pull_o,
  output logic cleared_o
);
  localparam int unsigned TIMEOUT_CYC = us_to_cyc(CLK_HZ, TIMEOUT_US);
  localparam int unsigned GUARD_CYC   = us_to_cyc(CLK_HZ, GUARD_US);
  localparam int unsigned HALF_CYC    = half_period_cyc(CLK_HZ, PULSE_HZ);

  logic fault_q, cleared_q;
  logic expire, rec_busy, rec_done, clr;

  stuck_timer #(.LIMIT(TIMEOUT_CYC)) timer_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (chan_en_i && !fault_q),
    .stuck_i  (!(scl_i && sda_i)),
    .expire_o (expire)
  );

  recovery_seq #(
    .GUARD_CYC (GUARD_CYC),
    .HALF_CYC  (HALF_CYC),
    .N_PULSES  (N_PULSES)
  ) seq_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (expire && disc_mode_i),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .busy_o     (rec_busy),
    .scl_pull_o (scl_pull_o),
    .sda_pull_o (sda_pull_o),
    .done_o     (rec_done)
  );

  // flag-only faults clear on bus high; recovery faults clear on sequencer done
  assign clr = fault_q && (rec_done || (!rec_busy && scl_i && sda_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q   <= 1'b0;
      cleared_q <= 1'b0;
    end else begin
      cleared_q <= clr;
      if (expire)   fault_q <= 1'b1;
      else if (clr) fault_q <= 1'b0;
    end
  end

  assign fault_o   = fault_q;
  assign isolate_o = rec_busy;
  assign cleared_o = cleared_q;
endmodule

// File: rtl/bus_unstick_ctrl_chk.sv
module bus_unstick_ctrl_chk
  import bus_unstick_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 125_000_000,
  parameter int unsigned GUARD_US = 40,
  parameter int unsigned N_PULSES = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic chan_en_i,
  input logic disc_mode_i,
  input logic fault_o,
  input logic isolate_o,
  input logic scl_pull_o,
  input logic sda_pull_o,
  input logic cleared_o
);
  localparam int unsigned GUARD_CYC = us_to_cyc(CLK_HZ, GUARD_US);

  int unsigned guard_cnt;
  int unsigned edge_cnt;
  logic scl_pull_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      guard_cnt     <= 0;
      edge_cnt      <= 0;
      scl_pull_prev <= 1'b0;
    end else begin
      scl_pull_prev <= scl_pull_o;
      if (!isolate_o) begin
        guard_cnt <= 0;
        edge_cnt  <= 0;
      end else begin
        if (guard_cnt < GUARD_CYC) guard_cnt <= guard_cnt + 1;
        if (scl_pull_o && !scl_pull_prev) edge_cnt <= edge_cnt + 1;
      end
    end
  end

  a_r5_pull_needs_isolate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_pull_o || sda_pull_o) |-> isolate_o);
  a_r5_isolate_needs_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isolate_o |-> fault_o);
  a_r5_guard_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_pull_o |-> (guard_cnt >= GUARD_CYC));
  a_r3_fault_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> $past(chan_en_i));
  a_r4_flag_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(fault_o) && !$past(disc_mode_i)) |-> !isolate_o);
  a_r6_pulse_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isolate_o |-> (edge_cnt <= N_PULSES + 1));
  a_r8_stop_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pull_o) |-> scl_pull_o);
  a_r8_stop_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_pull_o) |-> !scl_pull_o);
  a_r9_cleared_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cleared_o |-> (!fault_o && !isolate_o));
  a_r9_cleared_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cleared_o |=> !cleared_o);
endmodule

bind bus_unstick_ctrl bus_unstick_ctrl_chk #(
  .CLK_HZ   (CLK_HZ),
  .GUARD_US (GUARD_US),
  .N_PULSES (N_PULSES)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .chan_en_i   (chan_en_i),
  .disc_mode_i (disc_mode_i),
  .fault_o     (fault_o),
  .isolate_o   (isolate_o),
  .scl_pull_o  (scl_pull_o),
  .sda_pull_o  (sda_pull_o),
  .cleared_o   (cleared_o)
);

// File: tb/bus_unstick_ctrl_tb_top.sv
`timescale 1ns/1ps
module bus_unstick_ctrl_tb_top;
  // 1 cycle per us: timeout 60, guard 8, half-period 5
  localparam int CLK_HZ = 1_000_000;
  localparam int T = 60;
  localparam int G = 8;
  localparam int H = 5;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chan_en = 1'b0, disc = 1'b0;
  logic ext_scl_low = 1'b0, ext_sda_low = 1'b0;
  logic fault, iso, sclp, sdap, clrd;
  logic scl_line, sda_line;

  always #4 clk = ~clk;

  assign scl_line = !(ext_scl_low || sclp);
  assign sda_line = !(ext_sda_low || sdap);

  bus_unstick_ctrl #(
    .CLK_HZ(CLK_HZ), .TIMEOUT_US(T), .GUARD_US(G), .PULSE_HZ(CLK_HZ / (2 * H)), .N_PULSES(N)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .chan_en_i(chan_en), .disc_mode_i(disc),
    .fault_o(fault), .isolate_o(iso), .scl_pull_o(sclp), .sda_pull_o(sdap), .cleared_o(clrd)
  );

  int n_cmp = 0, n_bad = 0;

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 watch, 1 flagged, 2 guard, 3 pulse low,
  // 4 pulse released, 5 stop both low, 6 stop data low, 7 await bus high
  int ph = 0, m_cnt = 0, m_stuck = 0, m_pulses = 0;
  bit m_clr = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; m_cnt = 0; m_stuck = 0; m_pulses = 0; m_clr = 0;
    end else begin
      bit both;
      both = scl_line && sda_line;
      m_clr = 0;
      case (ph)
        0: if (chan_en && !both) begin
             if (m_stuck == T - 1) begin
               m_stuck = 0; m_cnt = 0; m_pulses = 0; ph = disc ? 2 : 1;
             end else m_stuck++;
           end else m_stuck = 0;
        1: if (both) begin ph = 0; m_clr = 1; end
        2: if (m_cnt == G - 1) begin ph = 3; m_cnt = 0; end else m_cnt++;
        3: if (m_cnt == H - 1) begin ph = 4; m_cnt = 0; end else m_cnt++;
        4: if (m_cnt == H - 1) begin
             m_cnt = 0; m_pulses++;
             ph = (both || m_pulses == N) ? 5 : 3;
           end else m_cnt++;
        5: if (m_cnt == H - 1) begin ph = 6; m_cnt = 0; end else m_cnt++;
        6: if (m_cnt == H - 1) begin ph = 7; m_cnt = 0; end else m_cnt++;
        7: if (both) begin ph = 0; m_clr = 1; end
        default: ph = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 fault_o", int'(fault), int'(ph != 0));
      check("R5 isolate_o", int'(iso), int'(ph >= 2));
      check("R6 scl_pull_o", int'(sclp), int'(ph == 3 || ph == 5));
      check("R8 sda_pull_o", int'(sdap), int'(ph == 5 || ph == 6));
      check("R9 cleared_o", int'(clrd), int'(m_clr));
    end
  end

  // bench-side pulse counter: clock pulls not coinciding with stop start
  int pulse_seen = 0;
  logic sclp_prev = 1'b0;
  always @(negedge clk) begin
    if (sclp && !sclp_prev && !sdap) pulse_seen++;
    sclp_prev = sclp;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    int cl_cnt;
    cyc(3);
    check("R1 fault_o reset", int'(fault), 0);
    check("R1 pulls reset", int'(sclp | sdap | iso), 0);
    rst_n = 1'b1;
    cyc(2);
    check("R1 cleared_o after reset", int'(clrd), 0);

    // healthy bus, enabled
    chan_en = 1'b1;
    cyc(100);
    check("R2 idle no fault", int'(fault), 0);

    // R3: disabled channels, data stuck
    chan_en = 1'b0; ext_sda_low = 1'b1;
    cyc(3 * T);
    check("R3 no fault while disabled", int'(fault), 0);

    // R2 restart: stuck windows broken by one high sample
    ext_sda_low = 1'b0; cyc(1);
    chan_en = 1'b1; ext_sda_low = 1'b1;
    cyc(T - 5);
    ext_sda_low = 1'b0; cyc(1);
    ext_sda_low = 1'b1;
    cyc(T - 5);
    check("R2 restart on both-high", int'(fault), 0);
    cyc(10);
    check("R2 fault after timeout", int'(fault), 1);

    // R4 flag-only
    cyc(30);
    check("R4 no isolate in flag mode", int'(iso | sclp | sdap), 0);
    ext_sda_low = 1'b0;
    cyc(1);
    check("R4 cleared pulse", int'(clrd), 1);
    check("R4 fault dropped", int'(fault), 0);
    cyc(1);
    check("R9 cleared one cycle", int'(clrd), 0);

    // R6 full train with data held low, R9 hold
    disc = 1'b1; cyc(5);
    pulse_seen = 0;
    ext_sda_low = 1'b1;
    cyc(T + 1);
    check("R5 isolate with fault", int'(iso), 1);
    cyc(G + N * 2 * H + 2 * H + 20);
    check("R6 pulse count max", pulse_seen, N);
    check("R9 fault held while stuck", int'(fault), 1);
    check("R9 isolate held while stuck", int'(iso), 1);
    ext_sda_low = 1'b0;
    cyc(1);
    check("R9 cleared after stop", int'(clrd), 1);
    check("R9 isolate released", int'(iso), 0);

    // R7 early stop after third pulse
    cyc(5);
    pulse_seen = 0;
    ext_sda_low = 1'b1;
    cl_cnt = 0;
    while (pulse_seen < 3 && cl_cnt < 5000) begin cyc(1); cl_cnt++; end
    ext_sda_low = 1'b0;
    cl_cnt = 0;
    while (!clrd && cl_cnt < 5000) begin cyc(1); cl_cnt++; end
    check("R7 early stop pulse count", pulse_seen, 3);
    check("R8 stop completed and cleared", int'(clrd), 1);

    // clock line stuck instead of data
    cyc(5);
    ext_scl_low = 1'b1;
    cyc(T + G + 4 * H);
    ext_scl_low = 1'b0;
    cl_cnt = 0;
    while (fault && cl_cnt < 5000) begin cyc(1); cl_cnt++; end
    check("R9 recovery from clock stuck", int'(fault), 0);
    cyc(10);
    finish_run();
  end
endmodule